// File: doc/BRIEF.md
# Operand Fetch Unit

This unit gathers the operand of an 8-bit accumulator processor once the opcode has been decoded into an addressing mode. A one-cycle start strobe hands it a mode code, a "wide" flag for 16-bit operands, the program counter and the index register. It then walks a byte-wide synchronous read port to collect the bytes that follow the opcode. When the last byte is captured it reports the effective address, the operand and the instruction length, and pulses done.

Each read is issued in one cycle and its data is used in the next. The port carries at most one read per clock. An address that depends on a fetched byte is formed from the returning data in the same cycle that the dependent read is issued, so no cycle is lost between the address bytes and the data reads. All inputs are latched when start is accepted. Nothing presented while the unit is busy has any effect.

Top module: `opnd_fetch_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, done_o, busy_o and mem_re_o are 0 and ea_o, operand_o and len_o are 0.
- R2: Mode code 0 (inherent) and the unused codes 6 and 7 issue no read and report ea_o = 0, operand_o = 0 and len_o = 1.
- R3: Mode code 1 (immediate) reads PC+1, and also PC+2 when wide_i = 1. The operand is that byte zero-extended, or {byte at PC+1, byte at PC+2}. ea_o is PC+1 and len_o is 2, or 3 when wide.
- R4: Mode code 2 (direct) uses the byte at PC+1 as the effective address, with the high address byte zero. len_o is 2.
- R5: Mode code 3 (indexed) uses the index register plus the byte at PC+1 as the effective address. The byte is taken as unsigned (0x80 adds 128). len_o is 2.
- R6: Mode code 4 (extended) uses {byte at PC+1, byte at PC+2} as the effective address. len_o is 3.
- R7: Mode code 5 (relative) makes exactly one read, at PC+1, for any wide_i. The operand is that byte sign-extended to 16 bits. ea_o is the branch target PC+2+offset. len_o is 2.
- R8: In modes 2 to 4 the operand is read at the effective address: one byte, zero-extended, or with wide_i = 1 the high byte at EA followed by the low byte at EA+1 in the next cycle.
- R9: Reads follow the order given above, one per clock. done_o is high for exactly one cycle, N+2 cycles after the start cycle, where N is the number of reads. busy_o falls on the following cycle.
- R10: ea_o, operand_o and len_o change only on the done cycle. A start pulse or a change of mode, flag, PC or index inputs while busy changes neither the reads nor the results.
- R11: All address arithmetic (PC+1, PC+2, index plus offset, EA+1, branch target) wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a fetch; accepted only when idle |
| mode_i | input | 3 | Addressing mode code (0 inherent, 1 immediate, 2 direct, 3 indexed, 4 extended, 5 relative) |
| wide_i | input | 1 | Operand is 16 bits |
| pc_i | input | 16 | Address of the opcode byte |
| ix_i | input | 16 | Index register value |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read |
| mem_re_o | output | 1 | Read strobe |
| mem_addr_o | output | 16 | Read address |
| ea_o | output | 16 | Effective address or branch target |
| operand_o | output | 16 | Fetched operand |
| len_o | output | 2 | Instruction length in bytes |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Fetch in progress |

## Verification
The assertions check on every cycle that done is a single-cycle pulse that ends the busy period, and that busy only rises after a start. They also check that no read is issued while idle or during an inherent fetch, that the low-byte read directly follows the high-byte read at the next address, and that the result outputs hold still except on the done cycle. Only the bench's scenarios can show the address arithmetic itself: the page-zero and unsigned-index effective addresses, the extended concatenation, the sign extension and the branch target. The same applies to wraparound at 0xFFFF, to the exact read order and latency per mode, and to inputs being ignored while busy. The bench predicts all of these from its own memory model.

// File: rtl/opf_pkg.sv
package opf_pkg;

  typedef enum logic [2:0] {
    AM_INH = 3'd0,
    AM_IMM = 3'd1,
    AM_DIR = 3'd2,
    AM_IDX = 3'd3,
    AM_EXT = 3'd4,
    AM_REL = 3'd5
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_B1,
    ST_RD_B2,
    ST_RD_HI,
    ST_RD_LO,
    ST_FIN,
    ST_DONE
  } fstate_e;

  typedef enum logic [1:0] {
    AS_PC1,
    AS_PC2,
    AS_EA,
    AS_EA1
  } asel_e;

  // Unused codes fall back to inherent behaviour
  function automatic amode_e norm_mode(input logic [2:0] code);
    if (code > 3'd5) return AM_INH;
    return amode_e'(code);
  endfunction

endpackage

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic          wide_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] ix_i,
  output amode_e        mode_q,
  output logic          wide_q,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] ix_q,
  output fstate_e       state_q,
  output logic          mem_re_o,
  output asel_e         asel_o,
  output logic          cap_b1_o,
  output logic          cap_ea_o,
  output logic          cap_hi_o,
  output logic          fin_o,
  output logic          done_o,
  output logic          busy_o
);

  fstate_e state_d;
  logic    accept_w;

  assign accept_w = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = (norm_mode(mode_i) == AM_INH) ? ST_FIN : ST_RD_B1;
      ST_RD_B1: begin
        case (mode_q)
          AM_IMM:  state_d = wide_q ? ST_RD_B2 : ST_FIN;
          AM_REL:  state_d = ST_FIN;
          AM_EXT:  state_d = ST_RD_B2;
          AM_DIR,
          AM_IDX:  state_d = ST_RD_HI;
          default: state_d = ST_FIN;
        endcase
      end
      ST_RD_B2: state_d = (mode_q == AM_EXT) ? ST_RD_HI : ST_FIN;
      ST_RD_HI: state_d = wide_q ? ST_RD_LO : ST_FIN;
      ST_RD_LO: state_d = ST_FIN;
      ST_FIN:   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= AM_INH;
      wide_q  <= 1'b0;
      pc_q    <= '0;
      ix_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        mode_q <= norm_mode(mode_i);
        wide_q <= wide_i;
        pc_q   <= pc_i;
        ix_q   <= ix_i;
      end
    end
  end

  always_comb begin
    mem_re_o = 1'b0;
    asel_o   = AS_PC1;
    case (state_q)
      ST_RD_B1: begin mem_re_o = 1'b1; asel_o = AS_PC1; end
      ST_RD_B2: begin mem_re_o = 1'b1; asel_o = AS_PC2; end
      ST_RD_HI: begin mem_re_o = 1'b1; asel_o = AS_EA;  end
      ST_RD_LO: begin mem_re_o = 1'b1; asel_o = AS_EA1; end
      default:  begin mem_re_o = 1'b0; asel_o = AS_PC1; end
    endcase
  end

  assign cap_b1_o = (state_q == ST_RD_B2);
  assign cap_ea_o = (state_q == ST_RD_HI);
  assign cap_hi_o = (state_q == ST_RD_LO);
  assign fin_o    = (state_q == ST_FIN);
  assign done_o   = (state_q == ST_DONE);
  assign busy_o   = (state_q != ST_IDLE);

endmodule

// File: rtl/opf_addr_calc.sv
module opf_addr_calc
  import opf_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  amode_e        mode_q,
  input  logic          wide_q,
  input  logic [AW-1:0] pc_q,
  input  logic [AW-1:0] ix_q,
  input  logic [BW-1:0] b1_q,
  input  logic [BW-1:0] rdata,
  input  logic [AW-1:0] ea_q,
  output logic [AW-1:0] pc_p1,
  output logic [AW-1:0] pc_p2,
  output logic [AW-1:0] ea_mem,
  output logic [AW-1:0] ea_p1,
  output logic [AW-1:0] rel_tgt,
  output logic [2*BW-1:0] rel_val,
  output logic [1:0]    len_val
);

  localparam int OW = 2 * BW;

  function automatic logic [AW-1:0] f_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [AW-1:0] f_zext(input logic [BW-1:0] v);
    return {{(AW-BW){1'b0}}, v};
  endfunction

  function automatic logic [AW-1:0] f_sext(input logic [BW-1:0] v);
    return {{(AW-BW){v[BW-1]}}, v};
  endfunction

  function automatic logic [1:0] f_len(input amode_e m, input logic w);
    case (m)
      AM_INH:  return 2'd1;
      AM_IMM:  return w ? 2'd3 : 2'd2;
      AM_EXT:  return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  assign pc_p1 = f_add(pc_q, AW'(1));
  assign pc_p2 = f_add(pc_q, AW'(2));
  assign ea_p1 = f_add(ea_q, AW'(1));

  // Address formed from the byte returning in the current cycle
  always_comb begin
    case (mode_q)
      AM_IDX:  ea_mem = f_add(ix_q, f_zext(rdata));
      AM_EXT:  ea_mem = AW'({b1_q, rdata});
      default: ea_mem = f_zext(rdata);
    endcase
  end

  assign rel_tgt = f_add(pc_p2, f_sext(rdata));
  assign rel_val = {{(OW-BW){rdata[BW-1]}}, rdata};
  assign len_val = f_len(mode_q, wide_q);

endmodule

// File: rtl/opf_result.sv
module opf_result
  import opf_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_b1,
  input  logic            cap_ea,
  input  logic            cap_hi,
  input  logic            fin,
  input  amode_e          mode_q,
  input  logic            wide_q,
  input  logic [BW-1:0]   rdata,
  input  logic [AW-1:0]   ea_mem,
  input  logic [AW-1:0]   pc_p1,
  input  logic [AW-1:0]   rel_tgt,
  input  logic [2*BW-1:0] rel_val,
  input  logic [1:0]      len_val,
  output logic [BW-1:0]   b1_q,
  output logic [AW-1:0]   ea_q,
  output logic [AW-1:0]   ea_o,
  output logic [2*BW-1:0] operand_o,
  output logic [1:0]      len_o
);

  localparam int OW = 2 * BW;

  logic [BW-1:0] hi_q;
  logic [AW-1:0] ea_d;
  logic [OW-1:0] opnd_d;

  always_comb begin
    ea_d   = '0;
    opnd_d = '0;
    case (mode_q)
      AM_IMM: begin
        ea_d   = pc_p1;
        opnd_d = wide_q ? {b1_q, rdata} : {{BW{1'b0}}, rdata};
      end
      AM_REL: begin
        ea_d   = rel_tgt;
        opnd_d = rel_val;
      end
      AM_DIR, AM_IDX, AM_EXT: begin
        ea_d   = ea_q;
        opnd_d = wide_q ? {hi_q, rdata} : {{BW{1'b0}}, rdata};
      end
      default: begin
        ea_d   = '0;
        opnd_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b1_q      <= '0;
      hi_q      <= '0;
      ea_q      <= '0;
      ea_o      <= '0;
      operand_o <= '0;
      len_o     <= '0;
    end else begin
      if (cap_b1) b1_q <= rdata;
      if (cap_ea) ea_q <= ea_mem;
      if (cap_hi) hi_q <= rdata;
      if (fin) begin
        ea_o      <= ea_d;
        operand_o <= opnd_d;
        len_o     <= len_val;
      end
    end
  end

endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
  import opf_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      mode_i,
  input  logic            wide_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [AW-1:0]   ix_i,
  input  logic [BW-1:0]   mem_rdata_i,
  output logic            mem_re_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [AW-1:0]   ea_o,
  output logic [2*BW-1:0] operand_o,
  output logic [1:0]      len_o,
  output logic            done_o,
  output logic            busy_o
);

  amode_e        mode_q;
  logic          wide_q;
  logic [AW-1:0] pc_q, ix_q;
  fstate_e       state_q;
  asel_e         asel_w;
  logic          cap_b1_w, cap_ea_w, cap_hi_w, fin_w;
  logic [BW-1:0] b1_q;
  logic [AW-1:0] ea_q, pc_p1, pc_p2, ea_mem, ea_p1, rel_tgt;
  logic [2*BW-1:0] rel_val;
  logic [1:0]    len_val;

  // Named events for the checker
  logic rd_lo_w;
  logic inh_busy_w;
  assign rd_lo_w    = (state_q == ST_RD_LO);
  assign inh_busy_w = busy_o && (mode_q == AM_INH);

  opf_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .wide_i(wide_i),
    .pc_i(pc_i), .ix_i(ix_i), .mode_q(mode_q), .wide_q(wide_q), .pc_q(pc_q), .ix_q(ix_q),
    .state_q(state_q), .mem_re_o(mem_re_o), .asel_o(asel_w), .cap_b1_o(cap_b1_w),
    .cap_ea_o(cap_ea_w), .cap_hi_o(cap_hi_w), .fin_o(fin_w), .done_o(done_o), .busy_o(busy_o)
  );

  opf_addr_calc #(.AW(AW), .BW(BW)) u_calc (
    .mode_q(mode_q), .wide_q(wide_q), .pc_q(pc_q), .ix_q(ix_q), .b1_q(b1_q),
    .rdata(mem_rdata_i), .ea_q(ea_q), .pc_p1(pc_p1), .pc_p2(pc_p2), .ea_mem(ea_mem),
    .ea_p1(ea_p1), .rel_tgt(rel_tgt), .rel_val(rel_val), .len_val(len_val)
  );

  opf_result #(.AW(AW), .BW(BW)) u_res (
    .clk(clk), .rst_n(rst_n), .cap_b1(cap_b1_w), .cap_ea(cap_ea_w), .cap_hi(cap_hi_w),
    .fin(fin_w), .mode_q(mode_q), .wide_q(wide_q), .rdata(mem_rdata_i), .ea_mem(ea_mem),
    .pc_p1(pc_p1), .rel_tgt(rel_tgt), .rel_val(rel_val), .len_val(len_val),
    .b1_q(b1_q), .ea_q(ea_q), .ea_o(ea_o), .operand_o(operand_o), .len_o(len_o)
  );

  always_comb begin
    case (asel_w)
      AS_PC2:  mem_addr_o = pc_p2;
      AS_EA:   mem_addr_o = ea_mem;
      AS_EA1:  mem_addr_o = ea_p1;
      default: mem_addr_o = pc_p1;
    endcase
  end

endmodule

// File: rtl/opf_chk.sv
module opf_chk #(
  parameter int AW = 16,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          done_o,
  input logic          busy_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] ea_o,
  input logic [OW-1:0] operand_o,
  input logic [1:0]    len_o,
  input logic          rd_lo_w,
  input logic          inh_w
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(busy_o)) |-> $past(start_i));

  // R10
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_re_o);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !done_o) |-> ($stable(operand_o) && $stable(ea_o) && $stable(len_o)));

  // R2
  inherent_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inh_w |-> !mem_re_o);

  // R8
  low_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd_lo_w) |-> (mem_re_o && $past(mem_re_o) && mem_addr_o == $past(mem_addr_o) + 16'd1));

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_o != 2'd0));

endmodule

bind opnd_fetch_unit opf_chk #(.AW(AW), .OW(2*BW)) u_opf_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .busy_o(busy_o),
  .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o), .ea_o(ea_o), .operand_o(operand_o),
  .len_o(len_o), .rd_lo_w(rd_lo_w), .inh_w(inh_busy_w)
);

// File: tb/tb_opnd_fetch_unit.sv
module tb_opnd_fetch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        wide_i = 1'b0;
  logic [15:0] pc_i = 16'h0;
  logic [15:0] ix_i = 16'h0;
  logic [7:0]  mem_rdata_i = 8'h0;
  logic        mem_re_o;
  logic [15:0] mem_addr_o;
  logic [15:0] ea_o;
  logic [15:0] operand_o;
  logic [1:0]  len_o;
  logic        done_o;
  logic        busy_o;

  int vectors = 0;
  int miscompares = 0;
  int clk_count = 0;

  logic [7:0] ov [int];

  always #10 clk = ~clk;

  opnd_fetch_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .wide_i(wide_i),
    .pc_i(pc_i), .ix_i(ix_i), .mem_rdata_i(mem_rdata_i), .mem_re_o(mem_re_o),
    .mem_addr_o(mem_addr_o), .ea_o(ea_o), .operand_o(operand_o), .len_o(len_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  function automatic int memfn(input int a);
    int aa;
    aa = a & 32'hFFFF;
    if (ov.exists(aa)) return int'(ov[aa]);
    return ((aa * 37) ^ (aa >> 8) ^ 32'hA5) & 32'hFF;
  endfunction

  always @(posedge clk) begin
    if (mem_re_o) mem_rdata_i <= 8'(memfn(int'(mem_addr_o)));
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    clk_count++;
    if (clk_count > 100000) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", clk_count);
      summary_and_end();
    end
  end

  task automatic run_op(input int m, input bit w, input int pc, input int ix,
                        input bit glitch, input string tag);
    int q[$];
    int ea, op, ln, b1, b2, d, off, mm, cyc, nreads;
    int s_ea, s_op, s_ln;
    bit got;
    mm = (m > 5) ? 0 : m;
    ea = 0; op = 0; ln = 1;
    case (mm)
      1: begin
        q.push_back((pc + 1) & 32'hFFFF);
        b1 = memfn(pc + 1);
        ea = (pc + 1) & 32'hFFFF;
        if (w) begin
          q.push_back((pc + 2) & 32'hFFFF);
          b2 = memfn(pc + 2);
          op = b1 * 256 + b2; ln = 3;
        end else begin
          op = b1; ln = 2;
        end
      end
      5: begin
        q.push_back((pc + 1) & 32'hFFFF);
        b1 = memfn(pc + 1);
        off = (b1 >= 128) ? b1 - 256 : b1;
        op = off & 32'hFFFF;
        ea = (pc + 2 + off) & 32'hFFFF;
        ln = 2;
      end
      2, 3, 4: begin
        q.push_back((pc + 1) & 32'hFFFF);
        b1 = memfn(pc + 1);
        if (mm == 4) begin
          q.push_back((pc + 2) & 32'hFFFF);
          b2 = memfn(pc + 2);
          ea = b1 * 256 + b2; ln = 3;
        end else if (mm == 2) begin
          ea = b1; ln = 2;
        end else begin
          ea = (ix + b1) & 32'hFFFF; ln = 2;
        end
        q.push_back(ea);
        d = memfn(ea);
        if (w) begin
          q.push_back((ea + 1) & 32'hFFFF);
          op = d * 256 + memfn(ea + 1);
        end else begin
          op = d;
        end
      end
      default: begin ea = 0; op = 0; ln = 1; end
    endcase
    nreads = q.size();

    @(negedge clk);
    mode_i = 3'(m); wide_i = w; pc_i = 16'(pc); ix_i = 16'(ix); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    got = 1'b0;
    while (!got && cyc <= 20) begin
      if (glitch) begin
        // R10: disturb every input while busy
        pc_i = ~16'(pc); ix_i = ~16'(ix); mode_i = 3'd4; wide_i = ~w; start_i = 1'b1;
      end
      if (mem_re_o) begin
        if (q.size() == 0) chk(tag, "unexpected read R9", int'(mem_addr_o), -1);
        else chk(tag, "read address R9", int'(mem_addr_o), q.pop_front());
      end
      if (done_o) got = 1'b1;
      else begin
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 1'b0;
    chk(tag, "done latency R9", cyc, nreads + 2);
    chk(tag, "reads left R9", q.size(), 0);
    chk(tag, "ea", int'(ea_o), ea);
    chk(tag, "operand", int'(operand_o), op);
    chk(tag, "length", int'(len_o), ln);
    s_ea = int'(ea_o); s_op = int'(operand_o); s_ln = int'(len_o);
    @(negedge clk);
    chk(tag, "done single cycle R9", int'(done_o), 0);
    chk(tag, "busy cleared R9", int'(busy_o), 0);
    pc_i = 16'hDEAD; mode_i = 3'd2;
    @(negedge clk);
    // R10: results held while idle, no stray read
    chk(tag, "idle read R10", int'(mem_re_o), 0);
    chk(tag, "hold ea R10", int'(ea_o), s_ea);
    chk(tag, "hold operand R10", int'(operand_o), s_op);
    chk(tag, "hold length R10", int'(len_o), s_ln);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "read strobe", int'(mem_re_o), 0);
    chk("R1", "ea/operand/len", int'(ea_o) | int'(operand_o) | int'(len_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", int'(busy_o), 0);

    // R2: inherent and unused codes
    run_op(0, 1'b0, 32'h1234, 32'h0, 1'b0, "R2");
    run_op(7, 1'b1, 32'h2222, 32'h0, 1'b0, "R2");
    run_op(6, 1'b0, 32'h0100, 32'h0, 1'b0, "R2");

    // R3: immediate 8 and 16
    run_op(1, 1'b0, 32'h1000, 32'h0, 1'b0, "R3");
    run_op(1, 1'b1, 32'h1100, 32'h0, 1'b0, "R3");
    // R11: immediate 16 across the top of memory
    run_op(1, 1'b1, 32'hFFFE, 32'h0, 1'b0, "R11");

    // R4: direct, 8 and 16 bit, high byte forced to zero
    ov[32'h2001] = 8'hFF;
    run_op(2, 1'b0, 32'h2000, 32'hABCD, 1'b0, "R4");
    run_op(2, 1'b1, 32'h2000, 32'hABCD, 1'b0, "R8");

    // R5: indexed, unsigned offset and wrap
    ov[32'h3001] = 8'h80;
    run_op(3, 1'b0, 32'h3000, 32'h1000, 1'b0, "R5");
    ov[32'h3101] = 8'h20;
    run_op(3, 1'b1, 32'h3100, 32'hFFF0, 1'b0, "R11");

    // R6: extended, 8 bit and wide at 0xFFFF
    run_op(4, 1'b0, 32'h4400, 32'h0, 1'b0, "R6");
    ov[32'h4001] = 8'hFF; ov[32'h4002] = 8'hFF;
    run_op(4, 1'b1, 32'h4000, 32'h0, 1'b0, "R8");

    // R7: relative, negative, positive, wide ignored, wrap
    ov[32'h5001] = 8'h80;
    run_op(5, 1'b0, 32'h5000, 32'h0, 1'b0, "R7");
    ov[32'h5101] = 8'h7F;
    run_op(5, 1'b1, 32'h5100, 32'h0, 1'b0, "R7");
    ov[32'h0000] = 8'h7F;
    run_op(5, 1'b0, 32'hFFFF, 32'h0, 1'b0, "R11");

    // R10: inputs disturbed while busy
    run_op(4, 1'b1, 32'h6000, 32'h0, 1'b1, "R10");
    run_op(0, 1'b0, 32'h6100, 32'h0, 1'b1, "R10");
    run_op(3, 1'b0, 32'h6200, 32'h0040, 1'b1, "R10");

    summary_and_end();
  end

endmodule